// File: doc/BRIEF.md
# Binary/Decimal Speculative Carry-Propagate Adder

This block turns two operand vectors into a single non-redundant sum. It is the final adder behind a multiplier's reduction stage, where one operand is the sum word and the other the carry word. A single mode pin picks the number system. With the pin low the block is an ordinary unsigned binary adder. With the pin high every 4-bit group holds one packed BCD digit, and the result is the decimal sum of the two digit strings.

Both modes share one carry network. That network is a sparse parallel-prefix tree and yields only the carry into each 4-bit group. Each group forms two candidate sums ahead of time, one for an incoming carry of 0 and one for 1, and the tree's carry selects between them. For decimal work, six is added in advance to every digit of the first operand. A group then carries out exactly when its decimal digit sum reaches ten, so the binary tree yields the right decimal carries. Each group whose selected sum does not carry out has the six taken back off (modulo 16) after selection.

The block is purely combinational. The width is a parameter and must be a multiple of 4. In decimal mode every input digit is assumed to lie in 0..9. Results for other digit codes are unspecified.

Top module: `bcd_bin_adder`

## Requirements
- R1: With `dec_mode`=0, `{carry_o, sum_o}` equals the unsigned sum `op_a + op_b` taken to W+1 bits.
- R2: With `dec_mode`=1 and valid BCD inputs, digit k of `sum_o` (bits 4k+3..4k, digit 0 least significant) is the decimal sum digit of the two operands. `carry_o` is the carry out of the top digit.
- R3: The carry into each 4-bit group matches a ripple carry through all lower groups. A carry entering at group 0 reaches `carry_o` across a full run of propagating groups.
- R4: With `dec_mode`=1 and valid BCD inputs, every 4-bit digit of `sum_o` lies in 0..9.
- R5: In decimal mode, a digit whose operand digits sum to exactly 9 passes an incoming carry on. It then shows digit 0 and is not corrected. Example: 99999999 + 00000001 gives 00000000 with `carry_o`=1.
- R6: In decimal mode, a digit whose sum reaches ten keeps the low 4 bits of its group sum. A digit that stays below ten has six removed modulo 16. Example: 5 + 5 gives digit 0 and a carry of 1 into the next digit.
- R7: With `dec_mode`=0, no six is added and no digit is corrected. Example: 0x9 + 0x1 gives 0xA.
- R8: The result depends only on the present inputs, with no clock or storage. Equal inputs always give equal outputs, zero inputs included.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | W | First operand (the sum word), 4-bit groups |
| op_b | input | W | Second operand (the carry word), 4-bit groups |
| dec_mode | input | 1 | 1 = packed BCD addition, 0 = binary addition |
| sum_o | output | W | Non-redundant result |
| carry_o | output | 1 | Carry out of the most significant group |

## Verification
Two things can happen in the same digit during one evaluation: the +6 correction and carry selection. A digit that sums to exactly nine looks, before selection, like one that must be corrected. Yet an incoming carry turns it into a carry-out that must leave its low bits alone. The bench provokes this with every pair of valid BCD digits on a two-digit adder. It also uses long runs of nines plus one on the full-width adder. Each result is judged against a digit-by-digit decimal sum computed in the bench.

// File: rtl/bcd_add_pkg.sv
package bcd_add_pkg;
  localparam int GRP_W = 4;
  localparam logic [3:0] SPEC_BIAS = 4'd6;
  localparam logic [3:0] MAX_DIGIT = 4'd9;
endpackage

// File: rtl/sel_group.sv
module sel_group
  import bcd_add_pkg::*;
(
  input  logic [GRP_W-1:0] a_i,
  input  logic [GRP_W-1:0] b_i,
  input  logic             dec_i,
  input  logic             cin_i,
  output logic [GRP_W-1:0] sum_o,
  output logic             gen_o,
  output logic             prop_o,
  output logic             cout_o
);
  logic [GRP_W-1:0] a_spec;
  logic [GRP_W:0]   raw_c0;
  logic [GRP_W:0]   raw_c1;
  logic [GRP_W:0]   picked;

  always_comb begin
    // speculative bias applied to one operand only
    a_spec = dec_i ? (a_i + SPEC_BIAS) : a_i;
    raw_c0 = {1'b0, a_spec} + {1'b0, b_i};
    raw_c1 = {1'b0, a_spec} + {1'b0, b_i} + {{GRP_W{1'b0}}, 1'b1};
    gen_o  = raw_c0[GRP_W];
    prop_o = (raw_c0[GRP_W-1:0] == {GRP_W{1'b1}});
    picked = cin_i ? raw_c1 : raw_c0;
    cout_o = picked[GRP_W];
    if (dec_i && !picked[GRP_W]) sum_o = picked[GRP_W-1:0] - SPEC_BIAS;
    else                         sum_o = picked[GRP_W-1:0];
  end

  always_comb begin
    // selected carry must agree with what the tree was told
    p_sel_carry_r3: assert (cout_o == (gen_o | (prop_o & cin_i)))
      else $error("group carry-out disagrees with generate/propagate");
    if (dec_i && (a_i <= MAX_DIGIT) && (b_i <= MAX_DIGIT)) begin
      p_digit_range_r4: assert (sum_o <= MAX_DIGIT)
        else $error("decimal digit out of range");
    end
  end
endmodule

// File: rtl/carry_tree.sv
module carry_tree #(
  parameter int NG = 8
) (
  input  logic [NG-1:0] g_i,
  input  logic [NG-1:0] p_i,
  output logic [NG:0]   c_o
);
  localparam int LV = (NG > 1) ? $clog2(NG) : 1;

  wire [NG-1:0] gl [0:LV];
  wire [NG-1:0] pl [0:LV];

  assign gl[0] = g_i;
  assign pl[0] = p_i;

  genvar lv, i;
  generate
    for (lv = 0; lv < LV; lv++) begin : g_lvl
      localparam int DIST = 1 << lv;
      for (i = 0; i < NG; i++) begin : g_node
        if (i >= DIST) begin : g_merge
          assign gl[lv+1][i] = gl[lv][i] | (pl[lv][i] & gl[lv][i-DIST]);
          assign pl[lv+1][i] = pl[lv][i] & pl[lv][i-DIST];
        end else begin : g_pass
          assign gl[lv+1][i] = gl[lv][i];
          assign pl[lv+1][i] = pl[lv][i];
        end
      end
    end
  endgenerate

  assign c_o = {gl[LV], 1'b0};

  always_comb begin
    for (int k = 0; k < NG; k++) begin
      p_gp_excl_r3: assert (!(g_i[k] & p_i[k]))
        else $error("group both generates and propagates");
      p_ripple_match_r3: assert (c_o[k+1] == (g_i[k] | (p_i[k] & c_o[k])))
        else $error("prefix carry differs from ripple carry");
    end
  end
endmodule

// File: rtl/bcd_bin_adder.sv
module bcd_bin_adder
  import bcd_add_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic         dec_mode,
  output logic [W-1:0] sum_o,
  output logic         carry_o
);
  localparam int NG = W / GRP_W;

  logic [NG-1:0] grp_g;
  logic [NG-1:0] grp_p;
  logic [NG-1:0] grp_co;
  logic [NG:0]   grp_c;

  carry_tree #(.NG(NG)) u_tree (
    .g_i (grp_g),
    .p_i (grp_p),
    .c_o (grp_c)
  );

  genvar gi;
  generate
    for (gi = 0; gi < NG; gi++) begin : g_grp
      sel_group u_grp (
        .a_i    (op_a[gi*GRP_W +: GRP_W]),
        .b_i    (op_b[gi*GRP_W +: GRP_W]),
        .dec_i  (dec_mode),
        .cin_i  (grp_c[gi]),
        .sum_o  (sum_o[gi*GRP_W +: GRP_W]),
        .gen_o  (grp_g[gi]),
        .prop_o (grp_p[gi]),
        .cout_o (grp_co[gi])
      );
    end
  endgenerate

  assign carry_o = grp_co[NG-1];

  logic [W:0] bin_ref;
  always_comb begin
    bin_ref = {1'b0, op_a} + {1'b0, op_b};
    if (!dec_mode) begin
      p_bin_sum_r1: assert ({carry_o, sum_o} == bin_ref)
        else $error("binary mode result mismatch");
    end
    p_top_carry_r3: assert (carry_o == grp_c[NG])
      else $error("top carry-out differs from tree carry");
  end
endmodule

// File: tb/tb_bcd_bin_adder.sv
`timescale 1ns/1ps
module tb_bcd_bin_adder;
  localparam int WN = 8;
  localparam int WW = 32;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [WN-1:0] na, nb, ns;
  logic          nd, nc;
  logic [WW-1:0] wa, wb, ws;
  logic          wd, wc;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  bcd_bin_adder #(.W(WN)) dut (
    .op_a(na), .op_b(nb), .dec_mode(nd), .sum_o(ns), .carry_o(nc)
  );
  bcd_bin_adder #(.W(WW)) dut_wide (
    .op_a(wa), .op_b(wb), .dec_mode(wd), .sum_o(ws), .carry_o(wc)
  );

  task automatic chk(input string req, input logic [32:0] act, input logic [32:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [32:0] dec_ref(input logic [31:0] a, input logic [31:0] b,
                                          input int ndig);
    logic [32:0] r = '0;
    int c = 0;
    for (int k = 0; k < ndig; k++) begin
      int s = int'(a[4*k +: 4]) + int'(b[4*k +: 4]) + c;
      if (s >= 10) begin s = s - 10; c = 1; end else c = 0;
      r[4*k +: 4] = 4'(s);
    end
    if (c != 0) r[4*ndig] = 1'b1;
    return r;
  endfunction

  task automatic wide(input logic [31:0] a, input logic [31:0] b, input logic d,
                      input string req);
    logic [32:0] exp;
    @(negedge clk);
    wa = a; wb = b; wd = d;
    #1;
    exp = d ? dec_ref(a, b, 8) : ({1'b0, a} + {1'b0, b});
    chk(req, {wc, ws}, exp);
  endtask

  initial begin
    #900000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    na = '0; nb = '0; nd = 1'b0;
    wa = '0; wb = '0; wd = 1'b0;
    // R8: zero inputs give zero outputs in both modes
    @(negedge clk); #1;
    chk("R8 zero bin", {wc, ws}, 33'd0);
    wd = 1'b1; #1;
    chk("R8 zero dec", {wc, ws}, 33'd0);

    // R1: exhaustive binary sweep on the narrow adder
    for (int x = 0; x < 256; x++) begin
      for (int y = 0; y < 256; y++) begin
        @(negedge clk);
        na = 8'(x); nb = 8'(y); nd = 1'b0;
        #1;
        chk("R1", {24'd0, nc, ns}, 33'(x + y));
      end
    end

    // R2/R4/R5/R6: every valid two-digit BCD pair
    for (int x = 0; x < 100; x++) begin
      for (int y = 0; y < 100; y++) begin
        logic [7:0] ax, by;
        ax = {4'(x / 10), 4'(x % 10)};
        by = {4'(y / 10), 4'(y % 10)};
        @(negedge clk);
        na = ax; nb = by; nd = 1'b1;
        #1;
        chk("R2", {24'd0, nc, ns}, dec_ref({24'd0, ax}, {24'd0, by}, 2));
        chk("R4", 33'((ns[3:0] > 4'd9) || (ns[7:4] > 4'd9)), 33'd0);
      end
    end

    // corner cases on the wide adder
    wide(32'hFFFF_FFFF, 32'h0000_0001, 1'b0, "R3 full propagate");
    wide(32'h0FFF_FFFF, 32'h0000_0001, 1'b0, "R3 partial propagate");
    wide(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, "R1 max");
    wide(32'h9999_9999, 32'h0000_0001, 1'b1, "R5 nines plus one");
    wide(32'h4545_4545, 32'h5454_5455, 1'b1, "R5 sum nine chain");
    wide(32'h0000_0005, 32'h0000_0005, 1'b1, "R6 five plus five");
    wide(32'h0000_0003, 32'h0000_0004, 1'b1, "R6 no carry digit");
    wide(32'h1234_5678, 32'h8765_4321, 1'b1, "R2 no carry");
    wide(32'h9999_9999, 32'h9999_9999, 1'b1, "R2 max");
    wide(32'h0000_0009, 32'h0000_0001, 1'b0, "R7 binary no bias");
    wide(32'h0000_0099, 32'h0000_0011, 1'b0, "R7 binary wrap");

    // R8: repeat the same input, result must be unchanged
    wide(32'h5000_0000, 32'h5000_0000, 1'b1, "R8 repeat a");
    wide(32'h5000_0000, 32'h5000_0000, 1'b1, "R8 repeat b");

    // pseudo-random sweep on the wide adder, both modes
    begin
      logic [31:0] lf = 32'h1ACE_B00C;
      for (int n = 0; n < 2000; n++) begin
        logic [31:0] ra, rb;
        lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
        ra = lf;
        lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
        rb = lf;
        wide(ra, rb, 1'b0, "R1 random");
        for (int k = 0; k < 8; k++) begin
          if (ra[4*k +: 4] > 4'd9) ra[4*k +: 4] = ra[4*k +: 4] - 4'd6;
          if (rb[4*k +: 4] > 4'd9) rb[4*k +: 4] = rb[4*k +: 4] - 4'd6;
        end
        wide(ra, rb, 1'b1, "R2 random");
      end
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule